// File: doc/BRIEF.md
# Supply and Watchdog Reset Generator

This block drives an active-low system reset from two causes. The first is a supply-good flag, `vcc_ok`, which stands for the digital output of a trip-voltage comparator. While the flag is low, reset is held. Once the flag has stayed high for an unbroken hold-off interval, reset is released. If the flag falls at any point during that interval, the interval starts over.

The second cause is a watchdog. A falling edge on the shared chip-select/watchdog line `cs_wdi` restarts it. That line is brought into the clock domain by a two-flop synchroniser before the edge is detected. A two-bit select picks one of three periods, or turns the watchdog off. If the period runs out with no falling edge, three things happen:
- the block emits a one-clock timeout pulse;
- it holds reset for a recovery time, whose length depends on which period was selected;
- it then restarts the watchdog from zero.

All times are counted in pulses of a slow timebase strobe `tick`, so every interval is a parameter in ticks.

Top module: `sup_reset_gen`

## Requirements
- R1: While `vcc_ok` is low, `reset_n` is low from the next clock on, and the hold-off count is cleared.
- R2: `reset_n` rises on the clock edge that samples the `POR_TICKS`-th tick during which `vcc_ok` has been continuously high.
- R3: A low pulse on `vcc_ok` during the hold-off interval discards the ticks counted so far. Release then needs a full `POR_TICKS` ticks after `vcc_ok` returns high.
- R4: A high-to-low transition of `cs_wdi`, seen after a two-flop synchroniser, clears the watchdog count, so regular kicks keep `reset_n` high.
- R5: With no falling edge, the watchdog times out on the `P`-th tick after it starts, whether `cs_wdi` is held high or held low. `P` is set by `wd_sel`: 2'b00 gives `WD_P00` (longest), 2'b01 gives `WD_P01`, and 2'b10 gives `WD_P10` (shortest).
- R6: With `wd_sel` = 2'b11 the watchdog is off, and neither a timeout pulse nor a reset is produced.
- R7: After a timeout, `reset_n` stays low for `HOLD_SHORT` ticks when the selection was 2'b00 or 2'b01, and for `HOLD_LONG` ticks when it was 2'b10.
- R8: `wdt_event` is high for exactly one clock, and it is high in the same cycle in which `reset_n` first goes low for the timeout.
- R9: The watchdog count is held at zero while reset is active. It starts from zero when reset is released, so the next timeout after a recovery again takes a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| tick | input | 1 | Timebase strobe, one clock wide |
| vcc_ok | input | 1 | Supply-good flag from the trip comparator |
| cs_wdi | input | 1 | Chip-select line, also used as the watchdog kick |
| wd_sel | input | 2 | Watchdog period select (11 = off) |
| reset_n | output | 1 | Active-low system reset |
| wdt_event | output | 1 | One-clock pulse on watchdog timeout |

## Verification
The bench counts ticks exactly, from the rise of `vcc_ok` to the release of reset, from release to timeout, and from timeout to the end of recovery. An off-by-one in any counter therefore shows up as a wrong tick count.

It checks that a short supply dip near the end of hold-off restarts the whole interval; a design that only paused the count would release early. It checks that a second timeout after recovery takes a full period; a design that did not clear the count during reset would fire early. It checks that the recovery length follows the selected period; a swapped mapping gives 2 ticks where 4 are expected.

It also holds the kick line steadily low, which must still time out. And it selects the off code, where a design that decoded the select wrongly would pulse `wdt_event`.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic vcc_ok,
  output logic done
);

  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!vcc_ok) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick && !done_q) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/sup_wdt_core.sv
module sup_wdt_core
  import sup_pkg::*;
#(
  parameter int WD_P00     = 14,
  parameter int WD_P01     = 6,
  parameter int WD_P10     = 4,
  parameter int HOLD_SHORT = 2,
  parameter int HOLD_LONG  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       hold,
  output logic       timeout
);

  localparam int unsigned MAXV = max_of3(max_of3(WD_P00, WD_P01, WD_P10), HOLD_SHORT, HOLD_LONG);
  localparam int CW = $clog2(MAXV + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] hlen_q, hlen_d;
  logic          hold_q, hold_d;
  logic          evt_q, evt_d;
  logic [CW-1:0] period;

  always_comb begin
    unique case (wd_sel_e'(sel))
      WD_LONG:  period = CW'(WD_P00);
      WD_MID:   period = CW'(WD_P01);
      WD_SHORT: period = CW'(WD_P10);
      default:  period = CW'(MAXV);
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    hlen_d = hlen_q;
    hold_d = hold_q;
    evt_d  = 1'b0;
    if (!enable) begin
      cnt_d  = '0;
      hold_d = 1'b0;
    end else if (hold_q) begin
      if (tick) begin
        if (cnt_q == hlen_q - 1'b1) begin
          cnt_d  = '0;
          hold_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (kick || (sel == WD_OFF)) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q >= period - 1'b1) begin
        cnt_d  = '0;
        hold_d = 1'b1;
        evt_d  = 1'b1;
        hlen_d = (sel == WD_SHORT) ? CW'(HOLD_LONG) : CW'(HOLD_SHORT);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hlen_q <= CW'(HOLD_SHORT);
      hold_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hlen_q <= hlen_d;
      hold_q <= hold_d;
      evt_q  <= evt_d;
    end
  end

  assign hold    = hold_q;
  assign timeout = evt_q;

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int POR_TICKS   = 8,
  parameter int WD_P00      = 14,
  parameter int WD_P01      = 6,
  parameter int WD_P10      = 4,
  parameter int HOLD_SHORT  = 2,
  parameter int HOLD_LONG   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       vcc_ok,
  input  logic       cs_wdi,
  input  logic [1:0] wd_sel,
  output logic       reset_n,
  output logic       wdt_event
);

  logic por_done;
  logic kick;
  logic wd_hold;

  sup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cs_wdi),
    .fall  (kick)
  );

  sup_hold_timer #(.TICKS(POR_TICKS)) u_por (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .vcc_ok (vcc_ok),
    .done   (por_done)
  );

  sup_wdt_core #(
    .WD_P00     (WD_P00),
    .WD_P01     (WD_P01),
    .WD_P10     (WD_P10),
    .HOLD_SHORT (HOLD_SHORT),
    .HOLD_LONG  (HOLD_LONG)
  ) u_wdt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .enable  (por_done),
    .kick    (kick),
    .sel     (wd_sel),
    .hold    (wd_hold),
    .timeout (wdt_event)
  );

  assign reset_n = por_done & ~wd_hold;

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       vcc_ok,
  input logic [1:0] wd_sel,
  input logic       reset_n,
  input logic       wdt_event
);

  // R1
  vcc_low_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> !reset_n);

  // R2
  release_on_good_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n) |-> ($past(vcc_ok) && $past(tick)));

  // R8
  event_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_event |=> !wdt_event);

  // R8
  event_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_event |-> (!reset_n && $past(reset_n)));

  // R6
  off_gives_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_event |-> ($past(wd_sel) != 2'b11));

endmodule

bind sup_reset_gen sup_reset_gen_chk u_chk (.*);

// File: tb/sup_reset_gen_bench.sv
`timescale 1ns/1ps
module sup_reset_gen_bench;

  localparam int POR = 8;
  localparam int P00 = 14;
  localparam int P01 = 6;
  localparam int P10 = 4;
  localparam int HS  = 2;
  localparam int HL  = 4;
  localparam int MAX_CLK = 150000;

  // columns: select code, expected period, expected recovery
  localparam int VEC [3][3] = '{'{0, P00, HS}, '{1, P01, HS}, '{2, P10, HL}};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       vcc_ok;
  logic       cs_wdi;
  logic [1:0] wd_sel;
  logic       reset_n;
  logic       wdt_event;

  int checks = 0;
  int fails  = 0;
  int tick_total = 0;
  int evt_count  = 0;
  int clk_count  = 0;
  bit run_tick   = 1'b0;

  sup_reset_gen #(
    .POR_TICKS(POR), .WD_P00(P00), .WD_P01(P01), .WD_P10(P10),
    .HOLD_SHORT(HS), .HOLD_LONG(HL), .SYNC_STAGES(2)
  ) u_sup_reset_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vcc_ok(vcc_ok),
    .cs_wdi(cs_wdi), .wd_sel(wd_sel), .reset_n(reset_n), .wdt_event(wdt_event)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    clk_count <= clk_count + 1;
    if (tick) tick_total <= tick_total + 1;
  end

  always @(negedge clk) if (wdt_event) evt_count <= evt_count + 1;

  initial begin
    tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick = run_tick;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  initial begin
    wait (clk_count >= MAX_CLK);
    fails = fails + 1;
    $display("FAIL watchdog: run hung, actual=%0d expected<%0d clocks", clk_count, MAX_CLK);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int t);
    int n = 0;
    @(negedge clk);
    while (!reset_n && n < 3000) begin
      @(negedge clk);
      n++;
    end
    t = tick_total;
  endtask

  task automatic wait_event(output int t);
    int n = 0;
    while (!wdt_event && n < 3000) begin
      @(negedge clk);
      n++;
    end
    t = tick_total;
  endtask

  task automatic power_up(input logic [1:0] sel, output int start);
    vcc_ok = 1'b0;
    wd_sel = sel;
    repeat (3) @(negedge clk);
    vcc_ok = 1'b1;
    start  = tick_total;
  endtask

  initial begin
    int s, t0, te, t1, te2, e0;
    rst_n  = 1'b0;
    vcc_ok = 1'b0;
    cs_wdi = 1'b1;
    wd_sel = 2'b00;
    repeat (3) @(negedge clk);
    // reset state
    check(reset_n == 1'b0, "R1 reset state", int'(reset_n), 0);
    check(wdt_event == 1'b0, "R8 reset state", int'(wdt_event), 0);
    rst_n = 1'b1;
    run_tick = 1'b1;
    repeat (20) @(negedge clk);
    check(reset_n == 1'b0, "R1 vcc low holds reset", int'(reset_n), 0);

    // table-driven: hold-off, period, recovery, restart after recovery
    for (int i = 0; i < 3; i++) begin
      power_up(2'(VEC[i][0]), s);
      wait_rise(t0);
      check(t0 - s == POR, "R2 hold-off ticks", t0 - s, POR);
      wait_event(te);
      check(te - t0 == VEC[i][1], "R5 period ticks", te - t0, VEC[i][1]);
      check(reset_n == 1'b0, "R8 reset low with event", int'(reset_n), 0);
      @(negedge clk);
      check(wdt_event == 1'b0, "R8 event one clock", int'(wdt_event), 0);
      wait_rise(t1);
      check(t1 - te == VEC[i][2], "R7 recovery ticks", t1 - te, VEC[i][2]);
      wait_event(te2);
      check(te2 - t1 == VEC[i][1], "R9 full period after recovery", te2 - t1, VEC[i][1]);
    end

    // R3: supply dip late in hold-off restarts the interval
    power_up(2'b11, s);
    while (tick_total < s + POR - 2) @(negedge clk);
    vcc_ok = 1'b0;
    @(negedge clk);
    vcc_ok = 1'b1;
    s = tick_total;
    wait_rise(t0);
    check(t0 - s == POR, "R3 restart after dip", t0 - s, POR);

    // R6: watchdog off never times out
    e0 = evt_count;
    s = tick_total;
    while (tick_total < s + 3 * P00) @(negedge clk);
    check(evt_count == e0, "R6 no event when off", evt_count - e0, 0);
    check(reset_n == 1'b1, "R6 reset stays released", int'(reset_n), 1);

    // R1: dropping supply while running asserts reset next clock
    vcc_ok = 1'b0;
    @(negedge clk);
    check(reset_n == 1'b0, "R1 drop asserts reset", int'(reset_n), 0);

    // R4: regular kicks with the middle period prevent a timeout
    power_up(2'b01, s);
    wait_rise(t0);
    e0 = evt_count;
    for (int k = 0; k < 10; k++) begin
      repeat (6) @(negedge clk);
      cs_wdi = 1'b0;
      repeat (6) @(negedge clk);
      cs_wdi = 1'b1;
    end
    check(evt_count == e0, "R4 kicks prevent timeout", evt_count - e0, 0);
    check(reset_n == 1'b1, "R4 reset stays released", int'(reset_n), 1);

    // R5: line held steadily low still times out
    cs_wdi = 1'b0;
    power_up(2'b10, s);
    wait_rise(t0);
    wait_event(te);
    check(te - t0 == P10, "R5 steady low period", te - t0, P10);

    run_tick = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule